// File: doc/BRIEF.md
# Shared Segment/Output Port Multiplexer

This block drives an output-only port whose pins are shared between plain general-purpose outputs and the segment (frontplane) lines of a display driver. Two registers sit behind a simple register-select interface: an output data latch and a routing register with one bit per pin. For each pin the block picks either the latched bit or the display segment value, which arrives as a plain input from a separate waveform generator.

Two force inputs, one per four-pin group, come from the display controller's control register. A set force hands its whole group to the data latch, whatever the routing bits hold. Read-back is shaped by the operating mode: the lowest data bit always reads high, the routing register refuses writes while the upper group is forced, and an option-map select hides the low routing bits on reads. Writes use a synchronous strobe. Read data is combinational. Reset is active-low and asynchronous.

Top module: `segport_mux`

## Requirements
- R1: After reset the data latch holds all ones, the routing register holds all zeros, and every pin follows its display segment input.
- R2: A pin whose routing bit is 1 drives its data latch bit. A pin whose routing bit is 0, with its group not forced, drives its display segment input.
- R3: While `nibForce[1]` is 1, pins 7..4 drive data latch bits 7..4, whatever the routing bits hold.
- R4: While `nibForce[0]` is 1, pins 3..0 drive data latch bits 3..0, whatever the routing bits hold.
- R5: A data register write always updates the latch, even for pins routed to the display. Such a write leaves those pins unchanged until they are routed to the latch, and the latch value then appears.
- R6: Reading the data register (`regSel`=0) returns the latch contents with bit 0 forced to 1.
- R7: A routing register write is ignored while `nibForce[1]` is 1. The write is accepted when only `nibForce[0]` is set.
- R8: While `optMapSel` is 1, a routing register read (`regSel`=1) returns 0 in bits 3..0. The stored bits are unchanged and reappear when `optMapSel` returns to 0.
- R9: `regSel`=0 addresses the data latch and `regSel`=1 the routing register. A write takes effect at the rising edge where `regWrEn` is 1. Neither register changes when `regWrEn` is 0, and a write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe, sampled on the rising edge |
| regSel | input | 1 | Register select: 0 data latch, 1 routing register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data of the selected register |
| nibForce | input | 2 | Group force: bit 1 for pins 7..4, bit 0 for pins 3..0 |
| optMapSel | input | 1 | Option-map select; hides routing bits 3..0 on reads |
| lcdSeg | input | 8 | Display segment drive values |
| portOut | output | 8 | Pin outputs |

## Verification
The bench builds the block with its defaults: 8 pins in two four-pin groups, and a hidden field four bits wide. This makes each group force visible on its own half of the port. It also puts the edge of the read mask at bit 4, so a routing pattern can show the hidden low bits beside the visible high bits. Test patterns set latch, segment and routing bits to differ pin by pin, so every pin shows which source it follows. One case clears latch bit 0 and then routes that pin to the latch, which separates the forced-high read from the real pin level.

// File: rtl/segport_pkg.sv
package segport_pkg;

  typedef enum logic {
    REG_DATA = 1'b0,
    REG_MUX  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic dataWr;
    logic muxWr;
    logic rdMux;
    logic hideLow;
  } seg_strobes_t;

endpackage

// File: rtl/segport_ctrl.sv
module segport_ctrl
  import segport_pkg::*;
(
  input  logic         regWrEn,
  input  logic         regSel,
  input  logic         upperForce,
  input  logic         optMapSel,
  output seg_strobes_t stb
);

  reg_sel_e sel;

  always_comb begin
    sel         = reg_sel_e'(regSel);
    stb.dataWr  = regWrEn && (sel == REG_DATA);
    stb.muxWr   = regWrEn && (sel == REG_MUX) && !upperForce;
    stb.rdMux   = (sel == REG_MUX);
    stb.hideLow = optMapSel;
  end

endmodule

// File: rtl/segport_datapath.sv
module segport_datapath
  import segport_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int GROUP_W   = 4,
  parameter int OPT_LOW_W = 4,
  parameter logic [PORT_W-1:0] READ_ONES = 1,
  localparam int NUM_GROUPS = PORT_W / GROUP_W
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  seg_strobes_t          stb,
  input  logic [PORT_W-1:0]     wrData,
  input  logic [NUM_GROUPS-1:0] groupForce,
  input  logic [PORT_W-1:0]     lcdSeg,
  output logic [PORT_W-1:0]     portOut,
  output logic [PORT_W-1:0]     rdData,
  output logic [PORT_W-1:0]     dataQ,
  output logic [PORT_W-1:0]     muxQ
);

  localparam logic [PORT_W-1:0] LOW_MASK =
    {{(PORT_W-OPT_LOW_W){1'b0}}, {OPT_LOW_W{1'b1}}};

  logic [PORT_W-1:0] pinGpio;
  logic [PORT_W-1:0] muxVisible;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '1;
    end else if (stb.dataWr) begin
      dataQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muxQ <= '0;
    end else if (stb.muxWr) begin
      muxQ <= wrData;
    end
  end

  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    assign pinGpio[p] = muxQ[p] | groupForce[p / GROUP_W];
    assign portOut[p] = pinGpio[p] ? dataQ[p] : lcdSeg[p];
  end

  always_comb begin
    muxVisible = stb.hideLow ? (muxQ & ~LOW_MASK) : muxQ;
    rdData     = stb.rdMux ? muxVisible : (dataQ | READ_ONES);
  end

endmodule

// File: rtl/segport_mux.sv
module segport_mux
  import segport_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int GROUP_W   = 4,
  parameter int OPT_LOW_W = 4,
  parameter logic [PORT_W-1:0] READ_ONES = 1,
  localparam int NUM_GROUPS = PORT_W / GROUP_W
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regSel,
  input  logic [PORT_W-1:0]     wrData,
  output logic [PORT_W-1:0]     rdData,
  input  logic [NUM_GROUPS-1:0] nibForce,
  input  logic                  optMapSel,
  input  logic [PORT_W-1:0]     lcdSeg,
  output logic [PORT_W-1:0]     portOut
);

  seg_strobes_t      stb;
  logic [PORT_W-1:0] dataQ;
  logic [PORT_W-1:0] muxQ;

  segport_ctrl i_ctrl (
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .upperForce (nibForce[NUM_GROUPS-1]),
    .optMapSel  (optMapSel),
    .stb        (stb)
  );

  segport_datapath #(
    .PORT_W    (PORT_W),
    .GROUP_W   (GROUP_W),
    .OPT_LOW_W (OPT_LOW_W),
    .READ_ONES (READ_ONES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .groupForce (nibForce),
    .lcdSeg     (lcdSeg),
    .portOut    (portOut),
    .rdData     (rdData),
    .dataQ      (dataQ),
    .muxQ       (muxQ)
  );

endmodule

// File: rtl/segport_mux_chk.sv
module segport_mux_chk #(
  parameter int PORT_W    = 8,
  parameter int GROUP_W   = 4,
  parameter int OPT_LOW_W = 4,
  localparam int NUM_GROUPS = PORT_W / GROUP_W
)(
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic                  regSel,
  input logic [PORT_W-1:0]     wrData,
  input logic [PORT_W-1:0]     rdData,
  input logic [NUM_GROUPS-1:0] nibForce,
  input logic                  optMapSel,
  input logic [PORT_W-1:0]     lcdSeg,
  input logic [PORT_W-1:0]     portOut,
  input logic [PORT_W-1:0]     dataQ,
  input logic [PORT_W-1:0]     muxQ
);

  for (genvar p = 0; p < PORT_W; p++) begin : g_pin_chk
    assert_seg_route_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!muxQ[p] && !nibForce[p / GROUP_W]) |-> (portOut[p] == lcdSeg[p]));
    assert_gpio_route_R2: assert property (@(posedge clk) disable iff (!rstN)
      muxQ[p] |-> (portOut[p] == dataQ[p]));
    if (p / GROUP_W == NUM_GROUPS - 1) begin : g_up
      assert_upper_force_R3: assert property (@(posedge clk) disable iff (!rstN)
        nibForce[NUM_GROUPS-1] |-> (portOut[p] == dataQ[p]));
    end
    if (p / GROUP_W == 0) begin : g_lo
      assert_lower_force_R4: assert property (@(posedge clk) disable iff (!rstN)
        nibForce[0] |-> (portOut[p] == dataQ[p]));
    end
  end

  assert_data_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel) |=> (dataQ == $past(wrData)));

  assert_read_bit0_R6: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> rdData[0]);

  assert_mux_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel && nibForce[NUM_GROUPS-1]) |=> $stable(muxQ));

  assert_opt_hide_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && optMapSel) |-> (rdData[OPT_LOW_W-1:0] == '0));

  assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(dataQ) && $stable(muxQ)));

  assert_data_sel_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel) |=> $stable(muxQ));

endmodule

bind segport_mux segport_mux_chk #(
  .PORT_W    (PORT_W),
  .GROUP_W   (GROUP_W),
  .OPT_LOW_W (OPT_LOW_W)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .wrData    (wrData),
  .rdData    (rdData),
  .nibForce  (nibForce),
  .optMapSel (optMapSel),
  .lcdSeg    (lcdSeg),
  .portOut   (portOut),
  .dataQ     (dataQ),
  .muxQ      (muxQ)
);

// File: tb/test_segport_mux.sv
module test_segport_mux;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [1:0] nibForce = 2'b00;
  logic       optMapSel = 1'b0;
  logic [7:0] lcdSeg = 8'h00;
  logic [7:0] portOut;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  segport_mux i_segport_mux (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .wrData    (wrData),
    .rdData    (rdData),
    .nibForce  (nibForce),
    .optMapSel (optMapSel),
    .lcdSeg    (lcdSeg),
    .portOut   (portOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] val);
    @(negedge clk);
    regSel  = sel;
    wrData  = val;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    #1;
  endtask

  task automatic read_reg(input logic sel, output logic [7:0] val);
    @(negedge clk);
    regSel = sel;
    #1;
    val = rdData;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    lcdSeg = 8'h5A;
    #1;
    check("R1 port follows segments", portOut, 8'h5A);
    read_reg(1'b0, v);
    check("R1 data latch reset", v, 8'hFF);
    read_reg(1'b1, v);
    check("R1 routing reset", v, 8'h00);
  endtask

  task automatic t_per_pin;
    write_reg(1'b1, 8'hA5);
    write_reg(1'b0, 8'h3C);
    lcdSeg = 8'h0F;
    #1;
    check("R2 per-pin mix", portOut, (8'h3C & 8'hA5) | (8'h0F & ~8'hA5));
    lcdSeg = 8'hF0;
    #1;
    check("R2 per-pin mix 2", portOut, (8'h3C & 8'hA5) | (8'hF0 & ~8'hA5));
  endtask

  task automatic t_write_hidden;
    logic [7:0] v;
    write_reg(1'b1, 8'h00);
    lcdSeg = 8'h96;
    write_reg(1'b0, 8'h00);
    check("R5 segment pins unaffected", portOut, 8'h96);
    read_reg(1'b0, v);
    check("R6 latch readback bit0 high", v, 8'h01);
    write_reg(1'b1, 8'hFF);
    check("R5 latch value appears when routed", portOut, 8'h00);
  endtask

  task automatic t_upper_force;
    write_reg(1'b1, 8'h00);
    write_reg(1'b0, 8'hC3);
    lcdSeg   = 8'h55;
    nibForce = 2'b10;
    #1;
    check("R3 upper group forced", portOut, 8'hC5);
    nibForce = 2'b00;
    #1;
    check("R3 force released", portOut, 8'h55);
  endtask

  task automatic t_lower_force;
    nibForce = 2'b01;
    #1;
    check("R4 lower group forced", portOut, 8'h53);
    nibForce = 2'b11;
    #1;
    check("R4 both groups forced", portOut, 8'hC3);
    nibForce = 2'b00;
  endtask

  task automatic t_mux_lock;
    logic [7:0] v;
    nibForce = 2'b10;
    write_reg(1'b1, 8'hFF);
    nibForce = 2'b00;
    read_reg(1'b1, v);
    check("R7 routing write blocked", v, 8'h00);
    #1;
    check("R7 pins still on segments", portOut, lcdSeg);
    nibForce = 2'b01;
    write_reg(1'b1, 8'h0F);
    nibForce = 2'b00;
    read_reg(1'b1, v);
    check("R7 lower force allows write", v, 8'h0F);
  endtask

  task automatic t_opt_map;
    logic [7:0] v;
    write_reg(1'b1, 8'hFF);
    optMapSel = 1'b1;
    read_reg(1'b1, v);
    check("R8 low routing bits hidden", v, 8'hF0);
    write_reg(1'b0, 8'h6A);
    read_reg(1'b0, v);
    check("R8 data read unaffected", v, 8'h6B);
    optMapSel = 1'b0;
    read_reg(1'b1, v);
    check("R8 stored bits retained", v, 8'hFF);
  endtask

  task automatic t_select;
    logic [7:0] v;
    @(negedge clk);
    regSel = 1'b0;
    wrData = 8'h11;
    @(negedge clk);
    regSel = 1'b1;
    @(negedge clk);
    read_reg(1'b0, v);
    check("R9 no strobe data unchanged", v, 8'h6B);
    read_reg(1'b1, v);
    check("R9 no strobe routing unchanged", v, 8'hFF);
    write_reg(1'b0, 8'h20);
    read_reg(1'b1, v);
    check("R9 data write spares routing", v, 8'hFF);
    write_reg(1'b1, 8'h81);
    read_reg(1'b0, v);
    check("R9 routing write spares data", v, 8'h21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_per_pin();
    t_write_hidden();
    t_upper_force();
    t_lower_force();
    t_mux_lock();
    t_opt_map();
    t_select();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule